// File: doc/BRIEF.md
# Serial Link Transmit Byte Sequencer with End-of-Frame CRC

This block feeds bytes of a J1850-style frame onto a bit-serial transmit path. Software loads bytes through a simple write strobe. The first byte goes straight into a shift register. A byte written while that register is busy waits in a one-byte holding slot. An empty flag tells software when it may write again. Bits leave MSB first, one per accepted valid/ready transfer.

To close a frame, software raises a finish request. The block drains the byte in flight and any held byte. It then appends the complemented CRC-8 of every data byte in the frame (polynomial 0x1D, preset 0xFF), MSB first. After the last CRC bit it gives a one-cycle pulse that asks the symbol layer for the end-of-data symbol.

In ordinary frames the finish request clears itself when the CRC goes out. In in-frame responses it stays set until the symbol layer reports a valid end-of-data echo. An error input flushes everything at once. A separate output gives the normalization bit for in-frame responses, chosen by a format select and whether the response carries a CRC.

Top module: `j1850_eod_tx`

## Requirements
- R1: A write (`wr_en` high while `tdre` is 1) with the shift register empty and nothing held loads the shift register. Data bits appear on `tx_bit`, MSB first, in write order, and one bit is consumed per cycle with `tx_valid` and `tx_ready` both high.
- R2: After the last data byte the block sends one CRC byte, MSB first. It is the bitwise complement of a CRC-8 with polynomial 0x1D and preset 0xFF, fed MSB first over all data bytes of the frame. The preset is restored after each frame and after an error.
- R3: `tdre` is 1 only when the holding slot is free and no finish request is pending. One cycle after a `eod_set` pulse, `eod_req` is 1 and `tdre` is 0.
- R4: If a byte is held when the finish request is made, the CRC follows the in-flight byte and then the held byte.
- R5: With `ifr_mode` at 0, `eod_req` is cleared by the time the first CRC bit is offered, so it reads 0 once `eod_sym` has pulsed.
- R6: With `ifr_mode` at 1, `eod_req` stays 1 after the CRC has gone out and clears one cycle after `eod_echo` is seen. `tdre` then returns to 1.
- R7: `eod_sym` is high for exactly one cycle, the cycle after the last CRC bit is accepted. `tx_valid` is 0 in that cycle unless new data has already been loaded.
- R8: One cycle after `err`, `tx_valid` is 0, `eod_req` is 0 and `tdre` is 1. The next frame's CRC starts again from the preset.
- R9: A write while `tdre` is 0 is ignored: the byte never appears on `tx_bit`.
- R10: `nb_bit` is 0 when `nb_fmt`=1 and `ifr_crc`=1, and 1 when `nb_fmt`=1 and `ifr_crc`=0. It is 1 when `nb_fmt`=0 and `ifr_crc`=1, and 0 when `nb_fmt`=0 and `ifr_crc`=0.
- R11: While `tx_valid` is 1 and `tx_ready` is 0, `tx_valid` stays 1 and `tx_bit` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Data byte write strobe |
| wr_data | input | 8 | Data byte to send |
| eod_set | input | 1 | Pulse requesting end of frame |
| ifr_mode | input | 1 | Current frame is an in-frame response |
| nb_fmt | input | 1 | Normalization bit format select |
| ifr_crc | input | 1 | In-frame response ends with a CRC byte |
| eod_echo | input | 1 | Valid end-of-data symbol received back |
| err | input | 1 | Bus error, aborts and flushes |
| tx_ready | input | 1 | Symbol layer accepts a bit |
| tdre | output | 1 | Holding slot free, write allowed |
| eod_req | output | 1 | Finish request pending |
| tx_valid | output | 1 | A bit is offered |
| tx_bit | output | 1 | Offered bit value |
| eod_sym | output | 1 | One-cycle end-of-data symbol request |
| nb_bit | output | 1 | Normalization bit value |

## Verification
Frames of one to six random bytes are sent under random ready throttling, in both ordinary and in-frame-response mode. The full bit stream is compared with bytes plus an independently computed CRC. This catches ordering, shift and CRC errors, and the mode difference in when the finish request clears. Directed frames with the ready line held low force a byte into the holding slot when the finish request is made. That separates correct CRC placement from early insertion, and shows that a write refused by the empty flag is dropped. An error in mid-frame, followed by a clean frame, shows whether the flush also resets the CRC. All four format/CRC combinations are applied to the normalization bit.

// File: rtl/j1850_eod_pkg.sv
package j1850_eod_pkg;

    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] CRC_POLY = 8'h1D;
    localparam logic [BYTE_W-1:0] CRC_SEED = 8'hFF;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DATA,
        ST_CRC,
        ST_ECHO
    } tx_state_e;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              full;
    } slot_t;

    function automatic logic [BYTE_W-1:0] crc_step(
        input logic [BYTE_W-1:0] cur,
        input logic [BYTE_W-1:0] din,
        input logic [BYTE_W-1:0] poly
    );
        logic [BYTE_W-1:0] c;
        logic              fb;
        c = cur;
        for (int i = BYTE_W - 1; i >= 0; i--) begin
            fb = c[BYTE_W-1] ^ din[i];
            c  = c << 1;
            if (fb) c = c ^ poly;
        end
        return c;
    endfunction

endpackage

// File: rtl/j1850_crc_acc.sv
module j1850_crc_acc
    import j1850_eod_pkg::*;
#(
    parameter logic [BYTE_W-1:0] POLY = CRC_POLY,
    parameter logic [BYTE_W-1:0] SEED = CRC_SEED
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              upd,
    input  logic [BYTE_W-1:0] din,
    output logic [BYTE_W-1:0] crc
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            crc <= SEED;
        end else if (upd) begin
            crc <= crc_step(crc, din, POLY);
        end
    end

endmodule

// File: rtl/j1850_nb_sel.sv
module j1850_nb_sel (
    input  logic nb_fmt,
    input  logic ifr_crc,
    output logic nb_bit
);

    always_comb begin
        if (nb_fmt) nb_bit = !ifr_crc;
        else        nb_bit = ifr_crc;
    end

endmodule

// File: rtl/j1850_eod_tx.sv
module j1850_eod_tx
    import j1850_eod_pkg::*;
#(
    parameter logic [BYTE_W-1:0] POLY = CRC_POLY,
    parameter logic [BYTE_W-1:0] SEED = CRC_SEED
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              eod_set,
    input  logic              ifr_mode,
    input  logic              nb_fmt,
    input  logic              ifr_crc,
    input  logic              eod_echo,
    input  logic              err,
    input  logic              tx_ready,
    output logic              tdre,
    output logic              eod_req,
    output logic              tx_valid,
    output logic              tx_bit,
    output logic              eod_sym,
    output logic              nb_bit
);

    localparam int               CNT_W    = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    slot_t             sh_q, sd_q;
    logic [CNT_W-1:0]  bcnt_q;
    tx_state_e         st_q;
    logic              eod_q, sym_q;

    logic              open_st, accept, done, free, wr_ok;
    logic              take_sd, take_wr, take_crc;
    logic              crc_clr, crc_upd;
    logic [BYTE_W-1:0] crc_din, crc_val;

    always_comb begin
        open_st  = (st_q == ST_IDLE) || (st_q == ST_DATA);
        accept   = sh_q.full && tx_ready;
        done     = accept && (bcnt_q == LAST_BIT);
        free     = !sh_q.full || done;
        wr_ok    = wr_en && open_st && !sd_q.full && !eod_q;
        take_sd  = free && open_st && sd_q.full;
        take_wr  = !sh_q.full && wr_ok;
        take_crc = free && open_st && eod_q && !sd_q.full && !wr_ok;
        crc_upd  = take_sd || take_wr;
        crc_din  = take_sd ? sd_q.data : wr_data;
        crc_clr  = err || (done && (st_q == ST_CRC));
    end

    j1850_crc_acc #(.POLY(POLY), .SEED(SEED)) crc_i (
        .clk (clk),
        .rst (rst),
        .clr (crc_clr),
        .upd (crc_upd),
        .din (crc_din),
        .crc (crc_val)
    );

    j1850_nb_sel nb_i (
        .nb_fmt  (nb_fmt),
        .ifr_crc (ifr_crc),
        .nb_bit  (nb_bit)
    );

    always_ff @(posedge clk) begin
        if (rst || err) begin
            sh_q   <= '0;
            sd_q   <= '0;
            bcnt_q <= '0;
            st_q   <= ST_IDLE;
            eod_q  <= 1'b0;
            sym_q  <= 1'b0;
        end else begin
            sym_q <= 1'b0;
            if (eod_set && open_st) eod_q <= 1'b1;
            if (accept) begin
                sh_q.data <= sh_q.data << 1;
                bcnt_q    <= bcnt_q + 1'b1;
            end
            if (wr_ok && sh_q.full) sd_q <= '{data: wr_data, full: 1'b1};
            if (take_sd) begin
                sh_q      <= '{data: sd_q.data, full: 1'b1};
                sd_q.full <= 1'b0;
                bcnt_q    <= '0;
                st_q      <= ST_DATA;
            end else if (take_wr) begin
                sh_q   <= '{data: wr_data, full: 1'b1};
                bcnt_q <= '0;
                st_q   <= ST_DATA;
            end else if (take_crc) begin
                sh_q   <= '{data: ~crc_val, full: 1'b1};
                bcnt_q <= '0;
                st_q   <= ST_CRC;
                if (!ifr_mode) eod_q <= 1'b0;
            end else if (done) begin
                sh_q.full <= 1'b0;
                if (st_q == ST_CRC) begin
                    sym_q <= 1'b1;
                    st_q  <= ifr_mode ? ST_ECHO : ST_IDLE;
                end
            end
            if ((st_q == ST_ECHO) && eod_echo) begin
                eod_q <= 1'b0;
                st_q  <= ST_IDLE;
            end
        end
    end

    assign tdre     = open_st && !sd_q.full && !eod_q;
    assign eod_req  = eod_q;
    assign tx_valid = sh_q.full;
    assign tx_bit   = sh_q.data[BYTE_W-1];
    assign eod_sym  = sym_q;

endmodule

// File: rtl/j1850_eod_tx_chk.sv
module j1850_eod_tx_chk (
    input logic clk,
    input logic rst,
    input logic err,
    input logic tdre,
    input logic eod_req,
    input logic tx_valid,
    input logic tx_ready,
    input logic tx_bit,
    input logic eod_sym
);

    p_tdre_eod_r3: assert property (@(posedge clk) disable iff (rst)
        eod_req |-> !tdre);

    p_sym_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        eod_sym |=> !eod_sym);

    p_err_flush_r8: assert property (@(posedge clk) disable iff (rst)
        err |=> (!tx_valid && !eod_req && tdre));

    p_hold_bit_r11: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready && !err) |=> (tx_valid && $stable(tx_bit)));

endmodule

bind j1850_eod_tx j1850_eod_tx_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .err      (err),
    .tdre     (tdre),
    .eod_req  (eod_req),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .tx_bit   (tx_bit),
    .eod_sym  (eod_sym)
);

// File: tb/j1850_eod_tx_tb_top.sv
module j1850_eod_tx_tb_top;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst, wr_en, eod_set, ifr_mode, nb_fmt, ifr_crc, eod_echo, err, tx_ready;
    logic [7:0] wr_data;
    logic       tdre, eod_req, tx_valid, tx_bit, eod_sym, nb_bit;

    j1850_eod_tx dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .eod_set(eod_set),
        .ifr_mode(ifr_mode), .nb_fmt(nb_fmt), .ifr_crc(ifr_crc), .eod_echo(eod_echo),
        .err(err), .tx_ready(tx_ready), .tdre(tdre), .eod_req(eod_req),
        .tx_valid(tx_valid), .tx_bit(tx_bit), .eod_sym(eod_sym), .nb_bit(nb_bit)
    );

    int         n_chk = 0;
    int         n_err = 0;
    int         sym_cnt = 0;
    int         nbits = 0;
    logic       bits [0:1023];
    logic [7:0] fb [0:7];
    logic       hold = 1'b1;
    logic       hold_val = 1'b0;

    always @(posedge clk) begin
        if (!rst && tx_valid && tx_ready && nbits < 1024) begin
            bits[nbits] = tx_bit;
            nbits++;
        end
        if (!rst && eod_sym) sym_cnt++;
    end

    always @(negedge clk) tx_ready <= hold ? hold_val : ($urandom_range(3) != 0);

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_crc(input int n);
        logic [7:0] c = 8'hFF;
        for (int b = 0; b < n; b++) begin
            for (int i = 7; i >= 0; i--) begin
                logic f = c[7] ^ fb[b][i];
                c = {c[6:0], 1'b0};
                if (f) c = c ^ 8'h1D;
            end
        end
        return ~c;
    endfunction

    task automatic write_byte(input logic [7:0] b);
        for (int k = 0; k < 2000 && !tdre; k++) @(negedge clk);
        wr_en = 1'b1;
        wr_data = b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic finish_frame(input int n, input bit ifr, input string req);
        int         s0 = sym_cnt;
        int         bad = 0;
        logic [7:0] cr = ref_crc(n);
        eod_set = 1'b1;
        @(negedge clk);
        eod_set = 1'b0;
        check(!tdre && eod_req, "R3", "tdre/eod_req after eod_set", {tdre, eod_req}, 2'b01);
        hold = 1'b0;
        for (int k = 0; k < 3000 && sym_cnt == s0; k++) @(negedge clk);
        check(sym_cnt == s0 + 1, "R7", "eod_sym pulses", sym_cnt - s0, 1);
        check(!eod_sym && !tx_valid, "R7", "pulse ended, line idle", {eod_sym, tx_valid}, 0);
        check(nbits == 8 * (n + 1), req, "bit count", nbits, 8 * (n + 1));
        for (int i = 0; i < 8 * (n + 1) && i < nbits; i++) begin
            logic e = (i < 8 * n) ? fb[i / 8][7 - (i % 8)] : cr[7 - (i % 8)];
            if (bits[i] !== e) bad++;
        end
        check(bad == 0, req, "R1/R2 stream mismatching bits", bad, 0);
        if (!ifr) begin
            check(eod_req == 1'b0, "R5", "eod_req after CRC, normal frame", eod_req, 0);
        end else begin
            check(eod_req == 1'b1, "R6", "eod_req held before echo", eod_req, 1);
            eod_echo = 1'b1;
            @(negedge clk);
            eod_echo = 1'b0;
            check(!eod_req && tdre, "R6", "eod_req/tdre after echo", {eod_req, tdre}, 2'b01);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd1850));
        rst = 1'b1; wr_en = 1'b0; wr_data = '0; eod_set = 1'b0; ifr_mode = 1'b0;
        nb_fmt = 1'b0; ifr_crc = 1'b0; eod_echo = 1'b0; err = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(tdre && !tx_valid && !eod_req && !eod_sym, "R3", "reset state",
              {tdre, tx_valid, eod_req, eod_sym}, 4'b1000);

        // R10: all four select/CRC combinations
        for (int m = 0; m < 4; m++) begin
            nb_fmt = m[1];
            ifr_crc = m[0];
            #1;
            check(nb_bit == (m[1] ? !m[0] : m[0]), "R10", "nb_bit", nb_bit, m[1] ? !m[0] : m[0]);
        end

        // R11: bit held while ready is low
        hold = 1'b1; hold_val = 1'b0;
        @(negedge clk);
        nbits = 0;
        fb[0] = 8'hA5;
        write_byte(fb[0]);
        repeat (3) begin
            @(negedge clk);
            check(tx_valid && tx_bit == 1'b1, "R11", "held bit", {tx_valid, tx_bit}, 2'b11);
        end
        finish_frame(1, 1'b0, "R1");

        // R4: byte held in slot when finish is requested
        hold = 1'b1;
        @(negedge clk);
        nbits = 0;
        fb[0] = 8'h3C; fb[1] = 8'hC7;
        write_byte(fb[0]);
        write_byte(fb[1]);
        check(!tdre, "R4", "slot full before finish", tdre, 0);
        finish_frame(2, 1'b0, "R4");

        // R9: write with tdre low is dropped
        hold = 1'b1;
        @(negedge clk);
        nbits = 0;
        fb[0] = 8'h11; fb[1] = 8'h22;
        write_byte(fb[0]);
        write_byte(fb[1]);
        check(!tdre, "R9", "tdre low before extra write", tdre, 0);
        wr_en = 1'b1; wr_data = 8'hEE;
        @(negedge clk);
        wr_en = 1'b0;
        finish_frame(2, 1'b0, "R9");

        // R6: in-frame response
        ifr_mode = 1'b1;
        @(negedge clk);
        nbits = 0;
        fb[0] = 8'h5A;
        write_byte(fb[0]);
        finish_frame(1, 1'b1, "R6");
        ifr_mode = 1'b0;

        // R8: error mid-frame, then a clean frame
        hold = 1'b0;
        write_byte(8'h77);
        write_byte(8'h88);
        eod_set = 1'b1;
        @(negedge clk);
        eod_set = 1'b0;
        err = 1'b1;
        @(negedge clk);
        err = 1'b0;
        check(!tx_valid && !eod_req && tdre, "R8", "flush after err",
              {tx_valid, eod_req, tdre}, 3'b001);
        nbits = 0;
        fb[0] = 8'h00;
        write_byte(fb[0]);
        finish_frame(1, 1'b0, "R8");

        // R1/R2 random frames
        for (int f = 0; f < 24; f++) begin
            int n = 1 + $urandom_range(5);
            bit ifr = $urandom_range(1);
            ifr_mode = ifr;
            @(negedge clk);
            nbits = 0;
            for (int b = 0; b < n; b++) begin
                fb[b] = 8'($urandom);
                write_byte(fb[b]);
            end
            finish_frame(n, ifr, "R2");
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule